// File: doc/BRIEF.md
# Clock Synthesizer Divider Configuration Loader

This block holds the divider settings of a clock synthesizer: a 9-bit feedback divide value (M), a 2-bit post-divide code (N) and a 3-bit test-select code (T). Two load paths feed these registers.

The parallel path is controlled by a level-sensitive load strobe. While the strobe is low, M and N pass straight through from the parallel inputs and T is held at zero. The rising edge of the strobe captures the parallel values and holds them.

The serial path has three wires: a data line, a serial clock and a transfer strobe. It fills a 14-bit shift register and works only while the parallel strobe is high. The falling edge of the transfer strobe commits the shifted word into M, N and T. The oldest bit in the shift register is also brought out as a serial-out tap for the test selector.

All strobe and serial-clock edges are detected in the block's own clock domain.

Top module: `cfg_loader`

## Requirements
- R1: After reset, with `par_load` high, `m_val`, `n_val`, `t_val` and `ser_out` are all zero.
- R2: Each rising edge of `ser_clk` seen while `par_load` is high shifts `ser_data` into bit 0 of the 14-bit shift register. `ser_out` is bit 13, so after 14 shifts it shows the first bit sent, and after one more it shows the second.
- R3: While `par_load` is low, `m_val` and `n_val` equal `par_m` and `par_n` combinationally, and `t_val` is zero.
- R4: Rising edges of `ser_clk` seen while `par_load` is low leave the shift register unchanged.
- R5: A falling edge of `ser_strobe` seen while `par_load` is high, and was high the cycle before, commits the shift register. Bits 13:11 go to `t_val`, bits 10:9 to `n_val` and bits 8:0 to `m_val`, so the stream is T2..T0, N1..N0, M8..M0, each field MSB first.
- R6: The rising edge of `par_load` captures `par_m` and `par_n` with T zero. Later changes on the parallel inputs do not affect the outputs while `par_load` stays high.
- R7: A falling edge of `ser_strobe` while `par_load` is low commits nothing.
- R8: When the `par_load` rising edge and a `ser_strobe` falling edge are seen in the same cycle, the parallel capture wins and the shift register is not committed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; all edges are detected on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| par_load | input | 1 | Parallel load strobe: transparent when low, captures on rise |
| par_m | input | 9 | Parallel M value |
| par_n | input | 2 | Parallel N code |
| ser_clk | input | 1 | Serial clock; data is sampled on its rising edge |
| ser_data | input | 1 | Serial data |
| ser_strobe | input | 1 | Serial transfer strobe; commits on its falling edge |
| m_val | output | 9 | Active M value |
| n_val | output | 2 | Active N code |
| t_val | output | 3 | Active test-select code |
| ser_out | output | 1 | Shift register MSB tap |

## Verification
Transparency while `par_load` is low is combinational, so the bench samples it one time unit after changing the parallel inputs. A shift, a parallel capture and a serial commit each land on the first `clk` rising edge that sees the new input level. The bench changes inputs on the falling edge of `clk` and holds each level for two clock periods. It then samples on a later falling edge, once every result is settled. The ignored-input cases (R4, R7, R8) are observed through a later commit or through the outputs directly.

// File: rtl/cfg_loader.sv
module cfg_loader #(
  parameter int M_W = 9,
  parameter int N_W = 2,
  parameter int T_W = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           par_load,
  input  logic [M_W-1:0] par_m,
  input  logic [N_W-1:0] par_n,
  input  logic           ser_clk,
  input  logic           ser_data,
  input  logic           ser_strobe,
  output logic [M_W-1:0] m_val,
  output logic [N_W-1:0] n_val,
  output logic [T_W-1:0] t_val,
  output logic           ser_out
);
  localparam int SR_W = T_W + N_W + M_W;

  logic            pl_q, sc_q, ss_q;
  logic [SR_W-1:0] sr;
  logic [M_W-1:0]  m_q;
  logic [N_W-1:0]  n_q;
  logic [T_W-1:0]  t_q;

  wire cap   = par_load & ~pl_q;
  wire shift = par_load & ser_clk & ~sc_q;
  wire xfer  = par_load & pl_q & ss_q & ~ser_strobe;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pl_q <= 1'b1;
      sc_q <= 1'b1;
      ss_q <= 1'b0;
      sr   <= '0;
      m_q  <= '0;
      n_q  <= '0;
      t_q  <= '0;
    end else begin
      pl_q <= par_load;
      sc_q <= ser_clk;
      ss_q <= ser_strobe;
      if (shift) sr <= {sr[SR_W-2:0], ser_data};
      if (!par_load || cap) begin
        m_q <= par_m;
        n_q <= par_n;
        t_q <= '0;
      end else if (xfer) begin
        {t_q, n_q, m_q} <= sr;
      end
    end
  end

  assign m_val   = par_load ? m_q : par_m;
  assign n_val   = par_load ? n_q : par_n;
  assign t_val   = par_load ? t_q : '0;
  assign ser_out = sr[SR_W-1];

  a_r2_tap_moves: assert property (@(posedge clk) disable iff (!rst_n)
    shift |=> ser_out == $past(sr[SR_W-2]));

  a_r3_transparent: assert property (@(posedge clk) disable iff (!rst_n)
    !par_load |-> (m_val == par_m && n_val == par_n && t_val == '0));

  a_r4_no_shift_when_low: assert property (@(posedge clk) disable iff (!rst_n)
    !par_load |=> $stable(sr));

  a_r5_commit: assert property (@(posedge clk) disable iff (!rst_n)
    xfer |=> {t_q, n_q, m_q} == $past(sr));

  a_r6_capture: assert property (@(posedge clk) disable iff (!rst_n)
    cap |=> (m_q == $past(par_m) && n_q == $past(par_n) && t_q == '0));

  a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (par_load && pl_q && !xfer) |=> ($stable(m_q) && $stable(n_q) && $stable(t_q)));
endmodule

// File: tb/cfg_loader_tb_top.sv
module cfg_loader_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       par_load = 1'b1;
  logic [8:0] par_m = '0;
  logic [1:0] par_n = '0;
  logic       ser_clk = 1'b0, ser_data = 1'b0, ser_strobe = 1'b0;
  logic [8:0] m_val;
  logic [1:0] n_val;
  logic [2:0] t_val;
  logic       ser_out;
  int checks = 0, fails = 0;

  always #4 clk = ~clk;

  cfg_loader dut_i (.clk(clk), .rst_n(rst_n), .par_load(par_load), .par_m(par_m),
    .par_n(par_n), .ser_clk(ser_clk), .ser_data(ser_data), .ser_strobe(ser_strobe),
    .m_val(m_val), .n_val(n_val), .t_val(t_val), .ser_out(ser_out));

  localparam logic [13:0] FRAMES [6] = '{
    14'b000_00_000000000, 14'b111_11_111111111, 14'b110_01_100000011,
    14'b101_10_010101010, 14'b001_11_000000001, 14'b010_00_111111110};

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic send_bit(logic b);
    ser_data = b; ser_clk = 1'b1; tick(2);
    ser_clk = 1'b0; tick(2);
  endtask

  task automatic send_frame(logic [13:0] f);
    for (int i = 13; i >= 0; i--) send_bit(f[i]);
  endtask

  task automatic strobe();
    ser_strobe = 1'b1; tick(2);
    ser_strobe = 1'b0; tick(2);
  endtask

  task automatic chk_out(string req, logic [13:0] f);
    chk(req, {23'd0, m_val}, {23'd0, f[8:0]});
    chk(req, {30'd0, n_val}, {30'd0, f[10:9]});
    chk(req, {29'd0, t_val}, {29'd0, f[13:11]});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    tick(4);
    rst_n = 1'b1;
    tick(2);
    chk_out("R1", 14'd0);
    chk("R1", {31'd0, ser_out}, 32'd0);

    for (int k = 0; k < 6; k++) begin
      send_frame(FRAMES[k]);
      chk("R2", {31'd0, ser_out}, {31'd0, FRAMES[k][13]});
      strobe();
      chk_out("R5", FRAMES[k]);
    end
    send_bit(1'b0);
    chk("R2", {31'd0, ser_out}, {31'd0, FRAMES[5][12]});

    // R3: transparency while par_load is low
    par_load = 1'b0; par_m = 9'd5; par_n = 2'd2;
    #1;
    chk("R3", {23'd0, m_val}, 32'd5);
    chk("R3", {29'd0, t_val}, 32'd0);
    par_m = 9'd7;
    #1;
    chk("R3", {23'd0, m_val}, 32'd7);
    par_m = 9'd5;
    tick(1);
    // R7: strobe while par_load is low commits nothing
    strobe();
    par_load = 1'b1; tick(2);
    chk_out("R7", {3'd0, 2'd2, 9'd5});
    // R6: hold after capture
    par_m = 9'h1AA; par_n = 2'd1; tick(2);
    chk_out("R6", {3'd0, 2'd2, 9'd5});

    // R4: shifts ignored while low
    send_frame(14'b011_01_110011001);
    par_load = 1'b0; tick(2);
    send_frame(14'b100_10_001100110);
    par_load = 1'b1; tick(2);
    chk_out("R6", {3'd0, 2'd1, 9'h1AA});
    strobe();
    chk_out("R4", 14'b011_01_110011001);

    // R8: capture and strobe fall in the same cycle
    par_load = 1'b0; par_m = 9'h0F0; par_n = 2'd3; ser_strobe = 1'b1; tick(2);
    par_load = 1'b1; ser_strobe = 1'b0; tick(3);
    chk_out("R8", {3'd0, 2'd3, 9'h0F0});

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule